// File: doc/BRIEF.md
# Framed Serial Command Parser

This block sits between a byte-wide serial receiver/transmitter pair and a simple 32-bit register bus. It watches the incoming byte stream for a frame-start marker, decodes a one-byte command, gathers the address and data bytes that command needs, and checks the closing marker. Only a fully closed frame causes a bus cycle. The three commands are: a reset that pulses a strobe to the attached cores, a register read, and a register write.

Every frame gets a short reply on the transmit side. A read reply carries the returned word. A write or reset reply only echoes the command. A command byte the block does not know gets an error reply. The address is split into a core selector byte and a register byte inside that core. Write data travels most significant byte first. The receiver itself cannot be stalled, so bytes that arrive while a reply is still draining are parsed into the next frame, and that frame's bus cycle waits until the reply has left.

Top module: `cmdp_parser`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block is cleared, and on the following cycle `tx_valid`, `bus_cs`, `bus_we` and `core_rst` are all low.
- R2: A frame opens with byte 0x55. Any byte received while hunting for a frame that is not 0x55 has no effect: it causes no reply, no bus cycle and no strobe.
- R3: The frame 0x55, 0x01, 0xAA raises `core_rst` for exactly one cycle without any bus cycle, and then sends the reply 0x55, 0x01, 0xAA.
- R4: The frame 0x55, 0x11, C, R, D3, D2, D1, D0, 0xAA gives exactly one cycle with `bus_cs` and `bus_we` both high, `bus_core`=C, `bus_reg`=R and `bus_wdata`={D3,D2,D1,D0}. The reply 0x55, 0x11, 0xAA follows.
- R5: The frame 0x55, 0x10, C, R, 0xAA gives exactly one cycle with `bus_cs` high and `bus_we` low, addressed to C/R. `bus_rdata` is sampled in the cycle after that one, and the reply is 0x55, 0x10, then the four sampled bytes most significant first, then 0xAA.
- R6: If the byte in the closing position of a reset, read or write frame is not 0xAA, the frame is dropped. There is no reply, no bus cycle and no strobe, and the block goes back to hunting for 0x55.
- R7: Any command byte other than 0x01, 0x10 or 0x11 gives the reply 0x55, 0xFE, 0xAA with no bus cycle. The block then hunts for 0x55 without waiting for a closing marker.
- R8: A reply byte transfers on a clock edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.
- R9: No bus cycle and no strobe happen while a reply is being sent. A frame that completes during a reply is carried out only after every byte of that reply has transferred.
- R10: `bus_we` is high only together with `bus_cs`, and `core_rst` is never high together with `bus_cs`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle pulse: a received byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter can take a reply byte |
| tx_valid | output | 1 | A reply byte is on `tx_data` |
| tx_data | output | 8 | Reply byte |
| core_rst | output | 1 | One-cycle reset strobe to the attached cores |
| bus_cs | output | 1 | Register bus select, one cycle per access |
| bus_we | output | 1 | Register bus write enable |
| bus_core | output | 8 | Core selector part of the bus address |
| bus_reg | output | 8 | Register part of the bus address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid in the cycle after a read select |

## Verification
The hardest case to reach from the ports is a second complete frame that arrives while a reply is still stuck in the transmitter. To build it, the bench holds `tx_ready` low, sends a read frame, and sends a write frame right after it. It then checks three things: the write has not reached the bus, the stalled reply byte stays put, and once `tx_ready` is released the write select appears only after the seventh reply byte has transferred. Random frames then run under a random `tx_ready` throttle, so later frames keep overlapping earlier replies, and bad closing bytes and unknown commands are mixed into directed cases.

// File: rtl/cmdp_pkg.sv
// Shared constants and types for the framed command parser.
// Assumes 8-bit bytes on both the receive and the transmit sides.
package cmdp_pkg;

    localparam logic [7:0] SOF_BYTE  = 8'h55;
    localparam logic [7:0] EOF_BYTE  = 8'hAA;
    localparam logic [7:0] OP_RESET  = 8'h01;
    localparam logic [7:0] OP_READ   = 8'h10;
    localparam logic [7:0] OP_WRITE  = 8'h11;
    localparam logic [7:0] RSP_ERROR = 8'hFE;

    typedef enum logic [2:0] {
        K_NONE,
        K_RESET,
        K_READ,
        K_WRITE,
        K_ERROR
    } kind_e;

endpackage

// File: rtl/cmdp_frame_rx.sv
// Frame decoder: hunts for the start marker, then classifies the command
// and collects the address and data bytes. It holds a finished command in
// the pending state until the top grants it with take.
// Assumes rx_valid is a single-cycle pulse per byte. Bytes that arrive while
// a command is pending are dropped.
module cmdp_frame_rx
    import cmdp_pkg::*;
#(
    parameter int DATA_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_data,
    input  logic                    take,
    output logic                    pend,
    output kind_e                   kind,
    output logic [7:0]              opcode,
    output logic [7:0]              core_sel,
    output logic [7:0]              reg_sel,
    output logic [8*DATA_BYTES-1:0] wdata
);

    localparam int WW = 8 * DATA_BYTES;
    localparam int CW = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

    typedef enum logic [2:0] {
        S_HUNT, S_OPC, S_CORE, S_REG, S_DATA, S_TAIL, S_PEND
    } state_e;

    state_e          state;
    logic [CW-1:0]   cnt;

    // Byte-driven parse state machine with field capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_HUNT;
            cnt      <= '0;
            kind     <= K_NONE;
            opcode   <= '0;
            core_sel <= '0;
            reg_sel  <= '0;
            wdata    <= '0;
        end else if (state == S_PEND) begin
            if (take) begin
                state <= S_HUNT;
            end
        end else if (rx_valid) begin
            case (state)
                S_HUNT: begin
                    if (rx_data == SOF_BYTE) begin
                        state <= S_OPC;
                    end
                end
                S_OPC: begin
                    opcode <= rx_data;
                    cnt    <= '0;
                    case (rx_data)
                        OP_RESET: begin
                            kind  <= K_RESET;
                            state <= S_TAIL;
                        end
                        OP_READ: begin
                            kind  <= K_READ;
                            state <= S_CORE;
                        end
                        OP_WRITE: begin
                            kind  <= K_WRITE;
                            state <= S_CORE;
                        end
                        default: begin
                            kind  <= K_ERROR;
                            state <= S_PEND;
                        end
                    endcase
                end
                S_CORE: begin
                    core_sel <= rx_data;
                    state    <= S_REG;
                end
                S_REG: begin
                    reg_sel <= rx_data;
                    state   <= (kind == K_WRITE) ? S_DATA : S_TAIL;
                end
                S_DATA: begin
                    wdata <= (wdata << 8) | WW'(rx_data);
                    if (cnt == CW'(DATA_BYTES - 1)) begin
                        state <= S_TAIL;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_TAIL: begin
                    state <= (rx_data == EOF_BYTE) ? S_PEND : S_HUNT;
                end
                default: begin
                    state <= S_HUNT;
                end
            endcase
        end
    end

    // A finished command waits here until granted.
    always_comb pend = (state == S_PEND);

endmodule

// File: rtl/cmdp_bus_exec.sv
// Bus executor: turns a granted command into a single-cycle register bus
// access or a reset strobe. It samples read data one cycle after the select
// and asks the reply sender to start. Address and write data are registers,
// so they stay stable through the access. rsp_code and rsp_word hold their
// values until the next grant, which cannot happen while a reply is in flight.
module cmdp_bus_exec
    import cmdp_pkg::*;
#(
    parameter int DATA_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  kind_e                   kind,
    input  logic [7:0]              opcode,
    input  logic [7:0]              core_in,
    input  logic [7:0]              reg_in,
    input  logic [8*DATA_BYTES-1:0] wdata_in,
    input  logic [8*DATA_BYTES-1:0] bus_rdata,
    output logic                    bus_cs,
    output logic                    bus_we,
    output logic [7:0]              bus_core,
    output logic [7:0]              bus_reg,
    output logic [8*DATA_BYTES-1:0] bus_wdata,
    output logic                    core_rst,
    output logic                    busy,
    output logic                    rsp_go,
    output logic                    rsp_read,
    output logic [7:0]              rsp_code,
    output logic [8*DATA_BYTES-1:0] rsp_word
);

    typedef enum logic [1:0] {X_IDLE, X_ACC, X_CAP} xstate_e;

    xstate_e st;
    logic    is_wr;

    // Access sequencer: select cycle, optional capture, reply launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= X_IDLE;
            is_wr     <= 1'b0;
            bus_cs    <= 1'b0;
            bus_we    <= 1'b0;
            bus_core  <= '0;
            bus_reg   <= '0;
            bus_wdata <= '0;
            core_rst  <= 1'b0;
            rsp_go    <= 1'b0;
            rsp_read  <= 1'b0;
            rsp_code  <= '0;
            rsp_word  <= '0;
        end else begin
            bus_cs   <= 1'b0;
            bus_we   <= 1'b0;
            core_rst <= 1'b0;
            rsp_go   <= 1'b0;
            case (st)
                X_IDLE: begin
                    if (take) begin
                        case (kind)
                            K_RESET: begin
                                core_rst <= 1'b1;
                                rsp_go   <= 1'b1;
                                rsp_read <= 1'b0;
                                rsp_code <= opcode;
                            end
                            K_READ: begin
                                bus_cs   <= 1'b1;
                                bus_core <= core_in;
                                bus_reg  <= reg_in;
                                rsp_code <= opcode;
                                is_wr    <= 1'b0;
                                st       <= X_ACC;
                            end
                            K_WRITE: begin
                                bus_cs    <= 1'b1;
                                bus_we    <= 1'b1;
                                bus_core  <= core_in;
                                bus_reg   <= reg_in;
                                bus_wdata <= wdata_in;
                                rsp_code  <= opcode;
                                is_wr     <= 1'b1;
                                st        <= X_ACC;
                            end
                            default: begin
                                rsp_go   <= 1'b1;
                                rsp_read <= 1'b0;
                                rsp_code <= RSP_ERROR;
                            end
                        endcase
                    end
                end
                X_ACC: begin
                    if (is_wr) begin
                        rsp_go   <= 1'b1;
                        rsp_read <= 1'b0;
                        st       <= X_IDLE;
                    end else begin
                        st <= X_CAP;
                    end
                end
                X_CAP: begin
                    rsp_word <= bus_rdata;
                    rsp_go   <= 1'b1;
                    rsp_read <= 1'b1;
                    st       <= X_IDLE;
                end
                default: st <= X_IDLE;
            endcase
        end
    end

    // Busy until the reply sender has taken the launch pulse.
    always_comb busy = (st != X_IDLE) || rsp_go;

endmodule

// File: rtl/cmdp_rsp_tx.sv
// Reply sender: walks a short frame one byte at a time over a valid/ready
// link. Byte 0 is the start marker, byte 1 the code, then (for reads) the
// word most significant byte first, and the end marker last. The code and
// word inputs must stay stable while busy.
module cmdp_rsp_tx
    import cmdp_pkg::*;
#(
    parameter int DATA_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go,
    input  logic                    with_data,
    input  logic [7:0]              code,
    input  logic [8*DATA_BYTES-1:0] word,
    input  logic                    tx_ready,
    output logic                    tx_valid,
    output logic [7:0]              tx_data,
    output logic                    busy
);

    localparam int RD_LEN = DATA_BYTES + 3;
    localparam int IW     = $clog2(RD_LEN + 1);

    logic          active;
    logic [IW-1:0] idx;
    logic [IW-1:0] last_idx;

    // Frame position counter, advanced on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            idx      <= '0;
            last_idx <= '0;
        end else if (go) begin
            active   <= 1'b1;
            idx      <= '0;
            last_idx <= with_data ? IW'(RD_LEN - 1) : IW'(2);
        end else if (active && tx_ready) begin
            if (idx == last_idx) begin
                active <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // Byte selection for the current frame position.
    always_comb begin
        tx_data = EOF_BYTE;
        if (idx == '0) begin
            tx_data = SOF_BYTE;
        end else if (idx == IW'(1)) begin
            tx_data = code;
        end else if (idx != last_idx) begin
            for (int k = 0; k < DATA_BYTES; k++) begin
                if (idx == IW'(k + 2)) begin
                    tx_data = word[8*(DATA_BYTES-1-k) +: 8];
                end
            end
        end
    end

    always_comb tx_valid = active;
    always_comb busy     = active;

endmodule

// File: rtl/cmdp_parser.sv
// Top of the framed command parser. It connects the frame decoder, the bus
// executor and the reply sender. A pending command is granted only when the
// executor is idle and no reply byte is left to send, so bus cycles never
// overlap a reply.
module cmdp_parser
    import cmdp_pkg::*;
#(
    parameter int DATA_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_data,
    input  logic                    tx_ready,
    output logic                    tx_valid,
    output logic [7:0]              tx_data,
    output logic                    core_rst,
    output logic                    bus_cs,
    output logic                    bus_we,
    output logic [7:0]              bus_core,
    output logic [7:0]              bus_reg,
    output logic [8*DATA_BYTES-1:0] bus_wdata,
    input  logic [8*DATA_BYTES-1:0] bus_rdata
);

    localparam int WW = 8 * DATA_BYTES;

    logic          pend;
    logic          take;
    kind_e         kind;
    logic [7:0]    opcode;
    logic [7:0]    core_sel;
    logic [7:0]    reg_sel;
    logic [WW-1:0] cmd_wdata;
    logic          exec_busy;
    logic          tx_busy;
    logic          rsp_go;
    logic          rsp_read;
    logic [7:0]    rsp_code;
    logic [WW-1:0] rsp_word;

    // Grant rule: one command at a time, never during a reply.
    always_comb take = pend && !exec_busy && !tx_busy;

    cmdp_frame_rx #(.DATA_BYTES(DATA_BYTES)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .take     (take),
        .pend     (pend),
        .kind     (kind),
        .opcode   (opcode),
        .core_sel (core_sel),
        .reg_sel  (reg_sel),
        .wdata    (cmd_wdata)
    );

    cmdp_bus_exec #(.DATA_BYTES(DATA_BYTES)) u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .kind      (kind),
        .opcode    (opcode),
        .core_in   (core_sel),
        .reg_in    (reg_sel),
        .wdata_in  (cmd_wdata),
        .bus_rdata (bus_rdata),
        .bus_cs    (bus_cs),
        .bus_we    (bus_we),
        .bus_core  (bus_core),
        .bus_reg   (bus_reg),
        .bus_wdata (bus_wdata),
        .core_rst  (core_rst),
        .busy      (exec_busy),
        .rsp_go    (rsp_go),
        .rsp_read  (rsp_read),
        .rsp_code  (rsp_code),
        .rsp_word  (rsp_word)
    );

    cmdp_rsp_tx #(.DATA_BYTES(DATA_BYTES)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (rsp_go),
        .with_data (rsp_read),
        .code      (rsp_code),
        .word      (rsp_word),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .busy      (tx_busy)
    );

endmodule

// File: rtl/cmdp_parser_chk.sv
// Protocol checker for cmdp_parser. It watches only the top-level ports and
// is attached with a bind statement.
module cmdp_parser_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       core_rst,
    input logic       bus_cs,
    input logic       bus_we
);

    // R1: outputs are quiet in the cycle after a reset edge.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!tx_valid && !bus_cs && !bus_we && !core_rst));

    // R3: the reset strobe lasts one cycle.
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> !core_rst);

    // R5: a bus select lasts one cycle.
    assert_cs_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs |=> !bus_cs);

    // R4: write enable only inside a select.
    assert_we_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> bus_cs);

    // R10: strobe and select never together.
    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> !bus_cs);

    // R8: a stalled reply byte is held.
    assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R9: no access or strobe while a reply is on the link.
    assert_quiet_during_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs || core_rst) |-> !tx_valid);

endmodule

bind cmdp_parser cmdp_parser_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .core_rst (core_rst),
    .bus_cs   (bus_cs),
    .bus_we   (bus_we)
);

// File: tb/cmdp_parser_tb.sv
module cmdp_parser_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        tx_ready = 1'b1;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        core_rst;
    logic        bus_cs;
    logic        bus_we;
    logic [7:0]  bus_core;
    logic [7:0]  bus_reg;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = 32'h0BAD0BAD;

    always #10 clk = ~clk;

    cmdp_parser u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .core_rst  (core_rst),
        .bus_cs    (bus_cs),
        .bus_we    (bus_we),
        .bus_core  (bus_core),
        .bus_reg   (bus_reg),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] mem [64];
    logic [7:0]  txbuf [2048];
    int          tx_got = 0;
    int          acc_cnt = 0;
    int          rst_cnt = 0;
    int          acc_tx_at = 0;
    logic        last_we = 1'b0;
    logic [7:0]  last_core = 8'h00;
    logic [7:0]  last_reg = 8'h00;
    logic [31:0] last_wdata = 32'h0;
    logic        rd_pend = 1'b0;
    logic [5:0]  rd_idx = 6'd0;
    logic        stall = 1'b0;
    logic        throttle = 1'b0;
    logic [7:0]  fb [16];
    int          fn = 0;
    logic [7:0]  eb [8];
    int          en = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] midx(input logic [7:0] c, input logic [7:0] r);
        return {c[2:0], r[2:0]};
    endfunction

    // Port monitor: reply bytes, strobes and bus accesses (also the target model).
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && tx_ready) begin
                txbuf[tx_got % 2048] = tx_data;
                tx_got++;
            end
            if (core_rst) rst_cnt++;
            if (bus_cs) begin
                acc_cnt++;
                acc_tx_at  = tx_got;
                last_we    = bus_we;
                last_core  = bus_core;
                last_reg   = bus_reg;
                last_wdata = bus_wdata;
                if (bus_we) mem[midx(bus_core, bus_reg)] = bus_wdata;
                else begin
                    rd_pend = 1'b1;
                    rd_idx  = midx(bus_core, bus_reg);
                end
            end
        end
    end

    // Target read data is valid only in the cycle after a read select; link throttle.
    always @(posedge clk) begin
        #1;
        if (rd_pend) begin
            bus_rdata = mem[rd_idx];
            rd_pend   = 1'b0;
        end else begin
            bus_rdata = 32'h0BAD0BAD;
        end
        tx_ready = stall ? 1'b0 : (throttle ? (($urandom % 4) != 0) : 1'b1);
    end

    task automatic send_byte(input logic [7:0] b);
        @(posedge clk); #1;
        rx_valid = 1'b1;
        rx_data  = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
        repeat ($urandom % 3) @(posedge clk);
    endtask

    task automatic build(input logic [7:0] op, input logic [7:0] c, input logic [7:0] r,
                         input logic [31:0] w);
        fb[0] = 8'h55; fb[1] = op; fn = 2;
        if (op == 8'h10 || op == 8'h11) begin
            fb[2] = c; fb[3] = r; fn = 4;
        end
        if (op == 8'h11) begin
            fb[4] = w[31:24]; fb[5] = w[23:16]; fb[6] = w[15:8]; fb[7] = w[7:0]; fn = 8;
        end
        fb[fn] = 8'hAA; fn++;
    endtask

    // Expected reply computed from the requirements and the target model.
    task automatic mk_rsp(input logic [7:0] op, input logic [7:0] c, input logic [7:0] r);
        logic [31:0] w;
        eb[0] = 8'h55;
        if (op == 8'h10) begin
            w = mem[midx(c, r)];
            eb[1] = 8'h10; eb[2] = w[31:24]; eb[3] = w[23:16];
            eb[4] = w[15:8]; eb[5] = w[7:0]; eb[6] = 8'hAA; en = 7;
        end else begin
            eb[1] = (op == 8'h01 || op == 8'h11) ? op : 8'hFE;
            eb[2] = 8'hAA; en = 3;
        end
    endtask

    task automatic send_fb();
        for (int i = 0; i < fn; i++) send_byte(fb[i]);
    endtask

    task automatic wait_tx(input int target);
        int t = 0;
        while (tx_got < target && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] op, input logic [7:0] c, input logic [7:0] r,
                             input logic [31:0] w, input string req,
                             input int exp_acc, input int exp_rst);
        int b_tx = tx_got;
        int b_acc = acc_cnt;
        int b_rst = rst_cnt;
        build(op, c, r, w);
        mk_rsp(op, c, r);
        send_fb();
        wait_tx(b_tx + en);
        chk({req, " reply length"}, tx_got - b_tx, en);
        for (int i = 0; i < en; i++) chk({req, " reply byte"}, txbuf[(b_tx + i) % 2048], eb[i]);
        chk({req, " access count"}, acc_cnt - b_acc, exp_acc);
        chk({req, " strobe count"}, rst_cnt - b_rst, exp_rst);
        if (op == 8'h11) begin
            chk("R4 write enable", last_we, 1);
            chk("R4 core select", last_core, c);
            chk("R4 register", last_reg, r);
            chk("R4 write word", last_wdata, w);
        end
        if (op == 8'h10) begin
            chk("R5 read has we low", last_we, 0);
            chk("R5 core select", last_core, c);
            chk("R5 register", last_reg, r);
        end
    endtask

    task automatic quiet_check(input string req, input int b_tx, input int b_acc, input int b_rst);
        repeat (30) @(negedge clk);
        chk({req, " no reply"}, tx_got - b_tx, 0);
        chk({req, " no access"}, acc_cnt - b_acc, 0);
        chk({req, " no strobe"}, rst_cnt - b_rst, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int b_tx;
        int b_acc;
        int b_rst;
        logic [7:0] held;
        logic [7:0] saved [7];
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 64; i++) mem[i] = (32'(i) * 32'h01010101) ^ 32'h13572468;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 bus_cs", bus_cs, 0);
        chk("R1 bus_we", bus_we, 0);
        chk("R1 core_rst", core_rst, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R2: noise while hunting, then a reset frame (R3).
        b_tx = tx_got; b_acc = acc_cnt; b_rst = rst_cnt;
        send_byte(8'h00); send_byte(8'hAA); send_byte(8'h13); send_byte(8'h11);
        quiet_check("R2", b_tx, b_acc, b_rst);
        run_frame(8'h01, 8'h00, 8'h00, 32'h0, "R3", 0, 1);

        // R4 then R5 read-back of the same register.
        run_frame(8'h11, 8'h01, 8'h02, 32'hDEADBEEF, "R4", 1, 0);
        run_frame(8'h10, 8'h01, 8'h02, 32'h0, "R5", 1, 0);
        run_frame(8'h10, 8'h07, 8'h05, 32'h0, "R5 untouched", 1, 0);

        // R6: wrong closing byte on a read and on a write.
        b_tx = tx_got; b_acc = acc_cnt; b_rst = rst_cnt;
        send_byte(8'h55); send_byte(8'h10); send_byte(8'h03); send_byte(8'h04); send_byte(8'h00);
        quiet_check("R6 read", b_tx, b_acc, b_rst);
        b_tx = tx_got;
        send_byte(8'h55); send_byte(8'h11); send_byte(8'h03); send_byte(8'h04);
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h04); send_byte(8'h12);
        quiet_check("R6 write", b_tx, b_acc, b_rst);
        run_frame(8'h10, 8'h03, 8'h04, 32'h0, "R6 recovery", 1, 0);

        // R7: unknown command; trailing closing byte is just noise.
        run_frame(8'h77, 8'h00, 8'h00, 32'h0, "R7", 0, 0);
        run_frame(8'h01, 8'h00, 8'h00, 32'h0, "R7 recovery", 0, 1);

        // R8/R9: second frame completes while the read reply is stalled.
        stall = 1'b1;
        b_tx = tx_got; b_acc = acc_cnt;
        build(8'h10, 8'h02, 8'h05, 32'h0);
        mk_rsp(8'h10, 8'h02, 8'h05);
        for (int i = 0; i < 7; i++) saved[i] = eb[i];
        send_fb();
        build(8'h11, 8'h02, 8'h06, 32'hCAFE0123);
        send_fb();
        repeat (20) @(negedge clk);
        chk("R9 write held back", acc_cnt - b_acc, 1);
        chk("R8 stalled valid", tx_valid, 1);
        held = tx_data;
        repeat (5) @(negedge clk);
        chk("R8 stalled data", tx_data, held);
        chk("R8 no transfer while stalled", tx_got - b_tx, 0);
        stall = 1'b0;
        wait_tx(b_tx + 10);
        chk("R9 both executed", acc_cnt - b_acc, 2);
        chk("R9 write after reply", acc_tx_at - b_tx, 7);
        chk("R9 write word", last_wdata, 32'hCAFE0123);
        for (int i = 0; i < 7; i++) chk("R9 read reply byte", txbuf[(b_tx + i) % 2048], saved[i]);
        chk("R9 ack code", txbuf[(b_tx + 8) % 2048], 8'h11);

        // Random traffic under a throttled link (R4, R5, R8, R3).
        throttle = 1'b1;
        for (int n = 0; n < 150; n++) begin
            int sel = $urandom % 10;
            logic [7:0]  c = 8'($urandom);
            logic [7:0]  r = 8'($urandom);
            logic [31:0] w = $urandom;
            if (sel < 4)       run_frame(8'h11, c, r, w, "R4 random", 1, 0);
            else if (sel < 9)  run_frame(8'h10, c, r, 32'h0, "R5 random", 1, 0);
            else               run_frame(8'h01, c, r, 32'h0, "R3 random", 0, 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule